// File: doc/BRIEF.md
# Status Word Flag Unit

This block holds the two 8-bit status words of a small 8-bit processor. The upper word keeps general control flags. The lower word carries the condition code in its top two bits. The upper word is changed and examined through masked operations. A masked set ORs a mask into the word. A masked clear removes the mask bits from it. A masked test compares the mask against the word and writes the condition code. Each of these operations takes three processor cycles.

The lower word moves directly between a memory data port and the status register, with no general register involved. An interrupt handler can therefore restore it as its final step, and the condition code it just restored stays intact. Instruction fetch, decode and interrupt sequencing belong to other blocks.

The parameter `LEGACY` sets how the two spare upper bits (weights 0x10 and 0x08) behave. When `LEGACY` is 0 they are writable user flags. When `LEGACY` is 1 they always read as zero.

Top module: `psw_flag_unit`

## Requirements
- R1: After reset, `upper` and `lower` are 0x00, `cc` is 2'b00, and `busy`, `done` and `mem_we` are low.
- R2: A masked set (`op_code` 3'd1) accepted at a clock edge makes `upper` = old upper OR `operand`. The change happens on the third edge after the accepting edge, and `done` is high for the cycle that follows that edge.
- R3: A masked clear (`op_code` 3'd2) makes `upper` = old upper AND NOT `operand`. It has the same three-cycle timing as R2.
- R4: With `LEGACY`=0, bit 4 (user flag 1, 0x10) and bit 3 (user flag 2, 0x08) of `upper` are set, cleared and tested exactly like the other bits.
- R5: With `LEGACY`=1, bits 4 and 3 of `upper` always read 0, whatever is written.
- R6: A masked test (`op_code` 3'd3) leaves `upper` unchanged. It writes `cc` = `lower[7:6]`: 2'b00 (equal) when every bit selected by `operand` is 1, and 2'b10 (less) otherwise. An empty mask gives equal. It has the same three-cycle timing as R2.
- R7: A direct load (`op_code` 3'd4) writes `mem_rdata` into `lower` on the accepting edge, so `cc` takes `mem_rdata[7:6]`. `done` is high for the next cycle, and `lower` keeps that value until a later load or test.
- R8: A direct store (`op_code` 3'd5) raises `mem_we` for exactly one cycle after the accepting edge, with `mem_wdata` = `lower`. `lower` is not changed.
- R9: While `busy` is high, any `op_valid` is ignored. An `op_code` outside 1..5 changes nothing and produces no `done`.
- R10: `done` is a single-cycle pulse and is never high together with `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation strobe |
| op_code | input | 3 | 1 set, 2 clear, 3 test, 4 load lower, 5 store lower |
| operand | input | 8 | Mask for set, clear and test |
| mem_rdata | input | 8 | Memory byte for the direct load |
| mem_wdata | output | 8 | Byte for the direct store (the lower word) |
| mem_we | output | 1 | Memory write strobe for the direct store |
| busy | output | 1 | A mask operation is in progress |
| done | output | 1 | Operation finished (one-cycle pulse) |
| cc | output | 2 | Condition code, equal to lower[7:6] |
| upper | output | 8 | Upper status word |
| lower | output | 8 | Lower status word |

## Verification
On every cycle, the assertions check these properties:
- `done` and `mem_we` are single-cycle pulses.
- `done` never coincides with `busy`.
- `busy` lasts past its first cycle.
- `upper` changes only on the edge that ends a mask operation.
- In legacy mode, the spare bits stay at zero.

Only the bench scenarios can show the rest:
- the actual values of set, clear and test;
- the equal and less outcomes, including the empty mask;
- a load followed by a store returning the same byte;
- operations dropped while busy, and unknown codes being inert.

// File: rtl/psw_flag_unit.sv
module psw_flag_unit #(
  parameter bit LEGACY = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       op_valid,
  input  logic [2:0] op_code,
  input  logic [7:0] operand,
  input  logic [7:0] mem_rdata,
  output logic [7:0] mem_wdata,
  output logic       mem_we,
  output logic       busy,
  output logic       done,
  output logic [1:0] cc,
  output logic [7:0] upper,
  output logic [7:0] lower
);

  localparam logic [2:0] OP_SET   = 3'd1;
  localparam logic [2:0] OP_CLR   = 3'd2;
  localparam logic [2:0] OP_TST   = 3'd3;
  localparam logic [2:0] OP_LDL   = 3'd4;
  localparam logic [2:0] OP_STL   = 3'd5;
  localparam logic [7:0] WR_MASK  = LEGACY ? 8'hE7 : 8'hFF;
  localparam logic [1:0] CC_EQ    = 2'b00;
  localparam logic [1:0] CC_LT    = 2'b10;

  logic [1:0] phase;
  logic [2:0] pend_op;
  logic [7:0] pend_mask;
  logic       accept, is_mask_op, last;
  logic [7:0] upper_q;

  assign busy       = phase != 2'd0;
  assign accept     = op_valid && !busy;
  assign is_mask_op = op_code == OP_SET || op_code == OP_CLR || op_code == OP_TST;
  assign last       = phase == 2'd3;
  assign upper      = upper_q & WR_MASK;
  assign cc         = lower[7:6];
  assign mem_wdata  = lower;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= 2'd0;
      pend_op   <= 3'd0;
      pend_mask <= 8'h00;
      upper_q   <= 8'h00;
      lower     <= 8'h00;
      done      <= 1'b0;
      mem_we    <= 1'b0;
    end else begin
      done   <= 1'b0;
      mem_we <= 1'b0;
      if (accept && is_mask_op) begin
        phase     <= 2'd1;
        pend_op   <= op_code;
        pend_mask <= operand;
      end else if (accept && op_code == OP_LDL) begin
        lower <= mem_rdata;
        done  <= 1'b1;
      end else if (accept && op_code == OP_STL) begin
        mem_we <= 1'b1;
        done   <= 1'b1;
      end else if (busy) begin
        phase <= last ? 2'd0 : phase + 2'd1;
        if (last) begin
          done <= 1'b1;
          case (pend_op)
            OP_SET:  upper_q <= (upper_q | pend_mask) & WR_MASK;
            OP_CLR:  upper_q <= upper_q & ~pend_mask & WR_MASK;
            default: lower[7:6] <= ((upper & pend_mask) == pend_mask) ? CC_EQ : CC_LT;
          endcase
        end
      end
    end
  end

endmodule

// File: rtl/psw_flag_unit_chk.sv
module psw_flag_unit_chk #(
  parameter bit LEGACY = 1'b0
) (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       done,
  input logic       mem_we,
  input logic [7:0] upper
);

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_not_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && busy));

  assert_we_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);

  assert_multi_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |=> busy);

  assert_upper_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(busy) |-> $stable(upper));

  assert_legacy_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    LEGACY |-> upper[4:3] == 2'b00);

endmodule

bind psw_flag_unit psw_flag_unit_chk #(.LEGACY(LEGACY)) u_chk (.*);

// File: tb/tb_psw_flag_unit.sv
module tb_psw_flag_unit;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_valid = 1'b0;
  logic [2:0] op_code = 3'd0;
  logic [7:0] operand = 8'h00;
  logic [7:0] mem_rdata = 8'h00;
  logic [7:0] wd, wd_l, up, lo, up_l, lo_l;
  logic       we, bsy, dn, we_l, bsy_l, dn_l;
  logic [1:0] cc, cc_l;
  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  psw_flag_unit #(.LEGACY(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .operand(operand), .mem_rdata(mem_rdata), .mem_wdata(wd), .mem_we(we),
    .busy(bsy), .done(dn), .cc(cc), .upper(up), .lower(lo));

  psw_flag_unit #(.LEGACY(1'b1)) dut_legacy (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .operand(operand), .mem_rdata(mem_rdata), .mem_wdata(wd_l), .mem_we(we_l),
    .busy(bsy_l), .done(dn_l), .cc(cc_l), .upper(up_l), .lower(lo_l));

  // {op, mask, expected upper, expected cc}
  localparam int NV = 8;
  localparam logic [20:0] VEC [NV] = '{
    {3'd1, 8'h81, 8'h81, 2'b00},
    {3'd1, 8'h18, 8'h99, 2'b00},
    {3'd3, 8'h18, 8'h99, 2'b00},
    {3'd2, 8'h10, 8'h89, 2'b00},
    {3'd3, 8'h18, 8'h89, 2'b10},
    {3'd3, 8'h00, 8'h89, 2'b00},
    {3'd2, 8'hFF, 8'h00, 2'b00},
    {3'd3, 8'h01, 8'h00, 2'b10}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op, input logic [7:0] m, input logic [7:0] rd);
    @(negedge clk);
    op_valid = 1'b1; op_code = op; operand = m; mem_rdata = rd;
    @(posedge clk);
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic mask_op(input logic [2:0] op, input logic [7:0] m);
    issue(op, m, 8'h00);
    check(bsy && !dn, "R2 busy during op", {bsy, dn}, 2'b10);
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(!dn, "R2 no early done", dn, 0);
    @(posedge clk);
    @(negedge clk);
    check(dn && !bsy, "R2 done after third cycle", {dn, bsy}, 2'b10);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(up == 8'h00 && lo == 8'h00 && cc == 2'b00, "R1 reset words", {up, lo}, 0);
    check(!bsy && !dn && !we, "R1 reset strobes", {bsy, dn, we}, 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      mask_op(VEC[i][20:18], VEC[i][17:10]);
      check(up == VEC[i][9:2], "R2/R3/R4 upper vector", up, VEC[i][9:2]);
      check(cc == VEC[i][1:0], "R6 cc vector", cc, VEC[i][1:0]);
    end

    // legacy spare bits
    mask_op(3'd1, 8'hFF);
    check(up_l == 8'hE7, "R5 legacy set reads zero", up_l, 8'hE7);
    check(up == 8'hFF, "R4 user flags writable", up, 8'hFF);
    mask_op(3'd3, 8'h10);
    check(cc_l == 2'b10, "R5 legacy test of flag gives less", cc_l, 2'b10);
    check(cc == 2'b00, "R4 flag test gives equal", cc, 2'b00);
    mask_op(3'd2, 8'h08);
    check(up == 8'hF7, "R4 clear user flag 2", up, 8'hF7);

    // direct load
    issue(3'd4, 8'h00, 8'h45);
    check(lo == 8'h45 && cc == 2'b01 && dn, "R7 direct load", {lo, cc}, {8'h45, 2'b01});
    @(negedge clk);
    check(!dn && lo == 8'h45, "R7 held after load", {dn, lo}, 8'h45);

    // direct store
    issue(3'd5, 8'h00, 8'hAA);
    check(we && wd == 8'h45 && lo == 8'h45, "R8 direct store", {we, wd}, {1'b1, 8'h45});
    @(negedge clk);
    check(!we, "R8 single write strobe", we, 0);

    // ignored while busy
    @(negedge clk);
    op_valid = 1'b1; op_code = 3'd1; operand = 8'h08;
    @(posedge clk);
    @(negedge clk);
    op_code = 3'd4; mem_rdata = 8'h00;
    @(posedge clk);
    @(negedge clk);
    op_code = 3'd2; operand = 8'hFF;
    @(posedge clk);
    @(negedge clk);
    op_valid = 1'b0;
    check(lo == 8'h45, "R9 load ignored while busy", lo, 8'h45);
    @(posedge clk);
    @(negedge clk);
    check(up == 8'hFF && dn, "R9 only first op applied", up, 8'hFF);

    // unknown code
    issue(3'd7, 8'hFF, 8'h00);
    check(!dn && !bsy && up == 8'hFF && lo == 8'h45, "R9 unknown code inert", {dn, bsy, up}, 8'hFF);
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(!dn && up == 8'hFF, "R10 no done for unknown code", dn, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule